// File: doc/BRIEF.md
# Cascadable Bidirectional Universal Shift Register

This block is a chain of identical 8-bit storage stages that together act as one long register. A two-bit mode select, sampled on the rising clock edge, picks one of four operations for the whole chain: keep the contents, move every bit one place toward the top, move every bit one place toward the bottom, or capture a parallel word. Each stage has its own bidirectional parallel port. It is modelled as a shared parallel input, a data-out bus and a per-stage output enable, and a wrapper at the pad ring resolves the actual tri-state pin.

Stages are linked end to end. The top bit of one stage feeds the bottom of the next stage during an upward shift, and the bottom bit of a stage feeds the top of the previous stage during a downward shift. A run-time recirculate input closes the chain into a ring, so that no bit is lost in either shift direction. An asynchronous active-low clear empties every stage at once.

Top module: `usr_chain`

## Requirements
- R1: With mode_sel = 2'b00 (hold), a clock edge leaves every bit of the chain unchanged.
- R2: With mode_sel = 2'b01 (shift up), a clock edge moves chain bit i to bit i+1, and bit 0 takes ser_lo_in when recirc is 0.
- R3: With mode_sel = 2'b10 (shift down), a clock edge moves chain bit i+1 to bit i, and the top chain bit takes ser_hi_in when recirc is 0.
- R4: With mode_sel = 2'b11 (load), a clock edge copies par_in into the chain, whatever the output enables are.
- R5: par_oe[k] is 1 exactly when oe1_n[k] and oe2_n[k] are both 0 and mode_sel is not 2'b11. A 1 on either enable releases that stage's port.
- R6: While mode_sel is 2'b11, no stage drives its port (par_oe is all zeros).
- R7: While clear_n is 0, every bit of the chain is 0 at once, without waiting for a clock edge, and whatever the other inputs are.
- R8: ser_lo_out always equals chain bit 0 and ser_hi_out always equals the top chain bit, whatever the output enables are.
- R9: Stage k occupies chain bits [8k+7:8k]. Shifts carry bits across stage boundaries as if the chain were one register.
- R10: With recirc = 1, shift up puts the old top bit into bit 0, shift down puts the old bit 0 into the top bit, and the serial inputs are ignored.
- R11: par_out always shows the chain contents, and par_oe qualifies each stage's byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Asynchronous active-low clear |
| mode_sel | input | 2 | Mode {hi,lo}: 00 hold, 01 shift up, 10 shift down, 11 load |
| recirc | input | 1 | 1 closes the chain into a ring |
| ser_lo_in | input | 1 | Serial input entering chain bit 0 on shift up |
| ser_hi_in | input | 1 | Serial input entering the top chain bit on shift down |
| oe1_n | input | STAGES | First active-low output enable, one per stage |
| oe2_n | input | STAGES | Second active-low output enable, one per stage |
| par_in | input | STAGES*WIDTH | Parallel port value as seen at the pins |
| par_out | output | STAGES*WIDTH | Chain contents, to drive the ports |
| par_oe | output | STAGES | Per-stage port drive enable |
| ser_lo_out | output | 1 | Chain bit 0 |
| ser_hi_out | output | 1 | Top chain bit |

## Verification
Every chain bit appears on par_out, so a wrong register value shows at the ports on the clock edge that produces it. It does not have to travel to a serial end first. A fault in the links between stages shows one edge after a shift that crosses a stage boundary. A fault in the recirculate path shows on the first shift with the ring closed. A fault in the drive logic shows as soon as the select or the enables settle, before any clock edge.

// File: rtl/usr_pkg.sv
// Package: shared mode type for the universal shift register chain.
// Assumes the mode select is presented as {hi,lo} on a two-bit bus.
package usr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_UP   = 2'b01,
        MODE_DOWN = 2'b10,
        MODE_LOAD = 2'b11
    } usr_mode_e;

endpackage

// File: rtl/usr_next_state.sv
// Module: computes the next contents of one stage from its mode, current
// contents, serial inputs at both ends and the parallel port value.
// Assumes the caller registers the result; purely combinational.
module usr_next_state
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  usr_mode_e        mode,
    input  logic [WIDTH-1:0] cur,
    input  logic             lo_in,
    input  logic             hi_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] nxt
);

    // Select the next value for the active mode.
    always_comb begin
        unique case (mode)
            MODE_HOLD: nxt = cur;
            MODE_UP:   nxt = {cur[WIDTH-2:0], lo_in};
            MODE_DOWN: nxt = {hi_in, cur[WIDTH-1:1]};
            MODE_LOAD: nxt = par_in;
            default:   nxt = cur;
        endcase
    end

endmodule

// File: rtl/usr_port_ctrl.sv
// Module: decides whether one stage drives its bidirectional port.
// Assumes both enables are active low; a load always releases the port.
module usr_port_ctrl
    import usr_pkg::*;
(
    input  usr_mode_e mode,
    input  logic      en1_n,
    input  logic      en2_n,
    output logic      drive
);

    logic enables_on;
    logic port_is_input;

    // Both enables must be asserted to allow driving.
    always_comb enables_on = ~en1_n & ~en2_n;

    // A load turns the port into an input.
    always_comb port_is_input = (mode == MODE_LOAD);

    // Final drive decision.
    always_comb drive = enables_on & ~port_is_input;

endmodule

// File: rtl/usr_stage.sv
// Module: one storage stage of the chain with its next-state logic and
// port drive control. Assumes neighbours supply the end serial inputs.
module usr_stage
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clear_n,
    input  usr_mode_e        mode,
    input  logic             lo_in,
    input  logic             hi_in,
    input  logic [WIDTH-1:0] par_in,
    input  logic             en1_n,
    input  logic             en2_n,
    output logic [WIDTH-1:0] q,
    output logic             drive
);

    logic [WIDTH-1:0] q_nxt;

    usr_next_state #(.WIDTH(WIDTH)) u_next (
        .mode   (mode),
        .cur    (q),
        .lo_in  (lo_in),
        .hi_in  (hi_in),
        .par_in (par_in),
        .nxt    (q_nxt)
    );

    usr_port_ctrl u_port (
        .mode  (mode),
        .en1_n (en1_n),
        .en2_n (en2_n),
        .drive (drive)
    );

    // Stage register with asynchronous active-low clear.
    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) q <= '0;
        else          q <= q_nxt;
    end

endmodule

// File: rtl/usr_chain.sv
// Module: top of the cascadable universal shift register. Chains STAGES
// stages so shifts cross stage boundaries, with an optional ring closure.
// Assumes one clock, mode and clear shared by all stages.
module usr_chain
    import usr_pkg::*;
#(
    parameter  int STAGES = 2,
    parameter  int WIDTH  = 8,
    localparam int TOT    = STAGES * WIDTH
) (
    input  logic              clk,
    input  logic              clear_n,
    input  logic [1:0]        mode_sel,
    input  logic              recirc,
    input  logic              ser_lo_in,
    input  logic              ser_hi_in,
    input  logic [STAGES-1:0] oe1_n,
    input  logic [STAGES-1:0] oe2_n,
    input  logic [TOT-1:0]    par_in,
    output logic [TOT-1:0]    par_out,
    output logic [STAGES-1:0] par_oe,
    output logic              ser_lo_out,
    output logic              ser_hi_out
);

    usr_mode_e      mode;
    logic [TOT-1:0] chain_q;
    logic           first_lo;
    logic           last_hi;

    // Decode the select bus into the mode type.
    always_comb mode = usr_mode_e'(mode_sel);

    // End inputs: external serial data or the opposite chain end.
    always_comb begin
        first_lo = recirc ? chain_q[TOT-1] : ser_lo_in;
        last_hi  = recirc ? chain_q[0]     : ser_hi_in;
    end

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        logic lo_k;
        logic hi_k;

        if (k == 0) begin : g_lo_end
            always_comb lo_k = first_lo;
        end else begin : g_lo_link
            always_comb lo_k = chain_q[k*WIDTH-1];
        end

        if (k == STAGES-1) begin : g_hi_end
            always_comb hi_k = last_hi;
        end else begin : g_hi_link
            always_comb hi_k = chain_q[(k+1)*WIDTH];
        end

        usr_stage #(.WIDTH(WIDTH)) u_stage (
            .clk     (clk),
            .clear_n (clear_n),
            .mode    (mode),
            .lo_in   (lo_k),
            .hi_in   (hi_k),
            .par_in  (par_in[k*WIDTH +: WIDTH]),
            .en1_n   (oe1_n[k]),
            .en2_n   (oe2_n[k]),
            .q       (chain_q[k*WIDTH +: WIDTH]),
            .drive   (par_oe[k])
        );
    end

    // Present contents and the serial ends.
    always_comb begin
        par_out    = chain_q;
        ser_lo_out = chain_q[0];
        ser_hi_out = chain_q[TOT-1];
    end

endmodule

// File: rtl/usr_chain_checker.sv
// Module: property checker for usr_chain, attached by bind below.
// Assumes the top's port names and parameter values.
module usr_chain_checker #(
    parameter  int STAGES = 2,
    parameter  int WIDTH  = 8,
    localparam int TOT    = STAGES * WIDTH
) (
    input logic              clk,
    input logic              clear_n,
    input logic [1:0]        mode_sel,
    input logic              recirc,
    input logic [STAGES-1:0] oe1_n,
    input logic [STAGES-1:0] oe2_n,
    input logic [TOT-1:0]    par_in,
    input logic [TOT-1:0]    par_out,
    input logic [STAGES-1:0] par_oe
);

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!clear_n)
        mode_sel == 2'b00 |=> $stable(par_out)); // R1

    AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!clear_n)
        mode_sel == 2'b01 |=> par_out[TOT-1:1] == $past(par_out[TOT-2:0])); // R2

    AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!clear_n)
        mode_sel == 2'b10 |=> par_out[TOT-2:0] == $past(par_out[TOT-1:1])); // R3

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!clear_n)
        mode_sel == 2'b11 |=> par_out == $past(par_in)); // R4

    AST_LOAD_RELEASED: assert property (@(posedge clk) disable iff (!clear_n)
        mode_sel == 2'b11 |-> par_oe == '0); // R6

    AST_CLEAR_EMPTY: assert property (@(posedge clk)
        !clear_n |-> par_out == '0); // R7

    AST_RING_UP: assert property (@(posedge clk) disable iff (!clear_n)
        (mode_sel == 2'b01 && recirc) |=> par_out[0] == $past(par_out[TOT-1])); // R10

    AST_RING_DOWN: assert property (@(posedge clk) disable iff (!clear_n)
        (mode_sel == 2'b10 && recirc) |=> par_out[TOT-1] == $past(par_out[0])); // R10

    for (genvar k = 0; k < STAGES; k++) begin : g_oe
        AST_DRIVE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!clear_n)
            par_oe[k] |-> (!oe1_n[k] && !oe2_n[k])); // R5
    end

endmodule

bind usr_chain usr_chain_checker #(.STAGES(STAGES), .WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .clear_n  (clear_n),
    .mode_sel (mode_sel),
    .recirc   (recirc),
    .oe1_n    (oe1_n),
    .oe2_n    (oe2_n),
    .par_in   (par_in),
    .par_out  (par_out),
    .par_oe   (par_oe)
);

// File: tb/tb_usr_chain.sv
`timescale 1ns/1ps
// Bench: scoreboard for usr_chain. A driver task applies one cycle of
// stimulus, updates a reference model and queues the expected contents;
// a monitor pops them after each rising edge and compares.
module tb_usr_chain;
    localparam int STAGES = 2;
    localparam int WIDTH  = 8;
    localparam int TOT    = STAGES * WIDTH;

    logic              clk = 1'b0;
    logic              clear_n = 1'b0;
    logic [1:0]        mode_sel = 2'b00;
    logic              recirc = 1'b0;
    logic              ser_lo_in = 1'b0;
    logic              ser_hi_in = 1'b0;
    logic [STAGES-1:0] oe1_n = '1;
    logic [STAGES-1:0] oe2_n = '1;
    logic [TOT-1:0]    par_in = '0;
    logic [TOT-1:0]    par_out;
    logic [STAGES-1:0] par_oe;
    logic              ser_lo_out;
    logic              ser_hi_out;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    logic [TOT-1:0] model = '0;
    logic [TOT-1:0] exp_q[$];
    string          tag_q[$];

    always #2.5 clk = ~clk;

    usr_chain #(.STAGES(STAGES), .WIDTH(WIDTH)) dut (
        .clk(clk), .clear_n(clear_n), .mode_sel(mode_sel), .recirc(recirc),
        .ser_lo_in(ser_lo_in), .ser_hi_in(ser_hi_in), .oe1_n(oe1_n),
        .oe2_n(oe2_n), .par_in(par_in), .par_out(par_out), .par_oe(par_oe),
        .ser_lo_out(ser_lo_out), .ser_hi_out(ser_hi_out)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [TOT-1:0] act, input logic [TOT-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: one clock of stimulus, enable check, model update, queue push.
    task automatic step(input logic [1:0] m, input logic rec, input logic sli,
                        input logic shi, input logic [TOT-1:0] pin,
                        input logic [STAGES-1:0] o1, input logic [STAGES-1:0] o2,
                        input string tag);
        logic [TOT-1:0] nxt;
        @(negedge clk);
        mode_sel = m; recirc = rec; ser_lo_in = sli; ser_hi_in = shi;
        par_in = pin; oe1_n = o1; oe2_n = o2;
        #1;
        for (int k = 0; k < STAGES; k++) begin
            logic eo;
            eo = (m != 2'b11) && !o1[k] && !o2[k];
            check(par_oe[k] === eo, (m == 2'b11) ? "R6 port released" : "R5 drive enable",
                  TOT'(par_oe[k]), TOT'(eo));
        end
        case (m)
            2'b00:   nxt = model;
            2'b01:   nxt = {model[TOT-2:0], rec ? model[TOT-1] : sli};
            2'b10:   nxt = {rec ? model[0] : shi, model[TOT-1:1]};
            default: nxt = pin;
        endcase
        model = nxt;
        exp_q.push_back(nxt);
        tag_q.push_back(tag);
    endtask

    // Asynchronous clear in the middle of a low clock phase.
    task automatic clear_pulse();
        @(negedge clk);
        mode_sel = 2'b00;
        #1 clear_n = 1'b0;
        #0.5;
        check(par_out === '0, "R7 async clear", par_out, '0);
        check(ser_lo_out === 1'b0 && ser_hi_out === 1'b0, "R7 R8 serial ends cleared",
              TOT'({ser_hi_out, ser_lo_out}), '0);
        model = '0;
        @(negedge clk);
        clear_n = 1'b1;
    endtask

    // Monitor: compare contents and serial ends after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [TOT-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(par_out === e, t, par_out, e);
                check(ser_lo_out === e[0] && ser_hi_out === e[TOT-1], "R8 serial ends",
                      TOT'({ser_hi_out, ser_lo_out}), TOT'({e[TOT-1], e[0]}));
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #1;
        check(par_out === '0, "R7 reset state", par_out, '0);
        check(par_oe === '0, "R5 reset enables off", TOT'(par_oe), '0);
        repeat (2) @(negedge clk);
        clear_n = 1'b1;

        // Load with both enables on: port must stay released (R4, R6).
        step(2'b11, 0, 0, 0, 16'hA5C3, 2'b00, 2'b00, "R4 load");
        step(2'b00, 0, 1, 1, 16'hFFFF, 2'b00, 2'b00, "R1 hold");
        step(2'b00, 0, 1, 1, 16'h1234, 2'b01, 2'b00, "R1 hold oe1 off");
        step(2'b00, 0, 0, 0, 16'h0000, 2'b00, 2'b10, "R11 contents with oe2 off");
        // Shift up with external serial data, crossing stages (R2, R9).
        step(2'b01, 0, 1, 0, 16'h0000, 2'b00, 2'b00, "R2 shift up in 1");
        step(2'b01, 0, 0, 1, 16'h0000, 2'b11, 2'b11, "R2 shift up in 0");
        step(2'b11, 0, 0, 0, 16'h0080, 2'b11, 2'b11, "R4 load with enables off");
        step(2'b01, 0, 0, 0, 16'h0000, 2'b00, 2'b00, "R9 carry up into stage 1");
        step(2'b10, 0, 0, 0, 16'h0000, 2'b00, 2'b00, "R9 carry down into stage 0");
        // Shift down with external serial data (R3).
        step(2'b10, 0, 0, 1, 16'h0000, 2'b00, 2'b00, "R3 shift down in 1");
        step(2'b10, 0, 1, 0, 16'h0000, 2'b00, 2'b00, "R3 shift down in 0");
        step(2'b10, 0, 0, 1, 16'h0000, 2'b01, 2'b01, "R3 shift down in 1 again");
        // Ring closed: serial inputs ignored, full rotation returns (R10).
        step(2'b11, 0, 0, 0, 16'h8001, 2'b00, 2'b00, "R4 load ring seed");
        for (int i = 0; i < TOT; i++)
            step(2'b01, 1, 0, 1, 16'h0000, 2'b00, 2'b00, "R10 ring shift up");
        step(2'b10, 1, 1, 0, 16'h0000, 2'b00, 2'b00, "R10 ring shift down");
        step(2'b10, 1, 0, 1, 16'h0000, 2'b00, 2'b00, "R10 ring shift down again");
        // Asynchronous clear, then recovery (R7).
        step(2'b11, 0, 0, 0, 16'h5AF0, 2'b00, 2'b00, "R4 load before clear");
        clear_pulse();
        step(2'b00, 0, 0, 0, 16'hFFFF, 2'b00, 2'b00, "R7 stays clear on hold");
        step(2'b11, 0, 0, 0, 16'h3C69, 2'b10, 2'b01, "R4 load after clear");
        step(2'b00, 0, 0, 0, 16'h0000, 2'b00, 2'b00, "R1 hold final");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule